// File: doc/BRIEF.md
# USB Controller Interrupt Status Register

This block collects the event pulses of a USB device/host controller into an 8-bit interrupt status register. Each event latches its own bit, and the bit stays set until software writes a one to that position. Software sees the raw bits through a read port. A per-bit enable mask decides which latched bits drive the single interrupt line to the processor. A separate OTG interrupt input is also ORed onto that line.

The token-completion source carries a transaction status word with every completion. The block keeps that word visible while the token-done bit is set. A second completion that arrives before software acknowledges the first one waits in a one-entry holding slot. When software clears token-done, the word is emptied, or the held entry is moved forward and token-done comes back one cycle later. A completion that finds both slots occupied is dropped, and an overflow flag records the loss.

The error bit is driven from a level-sensitive error-flag word and reacts to any flag that turns on. The attach bit is honoured only while host mode is selected.

Top module: `usb_irq_status`

## Requirements
- R1: After a synchronous reset the status read value is 0x00, the transaction status word is 0, the overflow flag is 0 and the interrupt line is low unless the OTG input is high.
- R2: The event inputs set status bits at fixed positions: bit 7 stall, bit 6 attach, bit 5 resume, bit 4 sleep, bit 3 token-done, bit 2 start-of-frame, bit 1 error, bit 0 bus reset. A bit is visible on the read port the cycle after its pulse.
- R3: A write with a one in a bit position clears that status bit on the next cycle. A zero in a bit position leaves that bit unchanged.
- R4: If an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: The interrupt output equals the OR over all eight bits of (status bit AND enable bit), ORed with the OTG interrupt input.
- R6: The read port returns the raw status bits regardless of the enable mask.
- R7: The error bit sets in the cycle after any bit of the error-flag word goes from 0 to 1. Flags that stay high do not set it again after it is cleared.
- R8: An attach pulse sets bit 6 only while the host-mode input is high. Otherwise it is ignored.
- R9: A completion while token-done is clear and nothing is pending loads its word into the transaction status word and sets token-done on the next cycle.
- R10: A completion while token-done is set and the holding slot is empty is held. Clearing token-done then gives one cycle with token-done low and word 0. In the following cycle token-done is set again with the held word.
- R11: Clearing token-done with nothing held makes the transaction status word 0 and token-done low.
- R12: A completion that finds both the word and the holding slot occupied is dropped and sets the overflow flag. The flag clears when token-done is cleared with nothing held.
- R13: A completion in the same cycle as a clear of token-done with nothing held keeps token-done set and replaces the word with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode_i | input | 1 | Host mode selected; qualifies attach |
| stall_i | input | 1 | Stall event pulse |
| attach_i | input | 1 | Attach event pulse |
| resume_i | input | 1 | Resume event pulse |
| sleep_i | input | 1 | Bus idle (sleep) event pulse |
| sof_i | input | 1 | Start-of-frame event pulse |
| bus_rst_i | input | 1 | Bus reset detected pulse |
| err_flags_i | input | ERR_W | Error-condition flag word (levels) |
| tok_done_i | input | 1 | Token completion pulse |
| tok_word_i | input | WORD_W | Transaction status word of the completion |
| otg_irq_i | input | 1 | OTG interrupt request |
| irq_en_i | input | 8 | Per-bit interrupt enable |
| wr_en_i | input | 1 | Write strobe for write-one-to-clear |
| wr_data_i | input | 8 | Write data; ones clear bits |
| rd_data_o | output | 8 | Raw status bits |
| xfer_stat_o | output | WORD_W | Current transaction status word |
| xfer_ovf_o | output | 1 | Completion dropped flag |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench targets a clear and an event landing on the same bit in one cycle. A design where the clear wins would lose the event and read back zero. It exercises the completion queue through every occupancy: held entry, simultaneous clear and completion, a third completion, and the refill gap. A wrong queue would show the held word too early, skip the one-cycle low gap, or overwrite the word instead of dropping it. Steady error flags, attach with host mode off and masked bits are also driven. A broken design would set error repeatedly, accept attach in device mode, or hide masked bits from the read port.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int NUM_SRC  = 8;
    localparam int B_STALL  = 7;
    localparam int B_ATTACH = 6;
    localparam int B_RESUME = 5;
    localparam int B_SLEEP  = 4;
    localparam int B_TOKDN  = 3;
    localparam int B_SOF    = 2;
    localparam int B_ERR    = 1;
    localparam int B_BUSRST = 0;

    // status bits in register order, bit 7 first
    typedef struct packed {
        logic stall;
        logic attach;
        logic resume;
        logic sleep;
        logic tok;
        logic sof;
        logic err;
        logic busrst;
    } irq_vec_t;

    // occupancy of the completion queue
    typedef enum logic [1:0] {
        Q_EMPTY  = 2'd0,
        Q_HEAD   = 2'd1,
        Q_FULL   = 2'd2,
        Q_REFILL = 2'd3
    } q_state_e;

    function automatic logic irq_any(input logic [NUM_SRC-1:0] st,
                                     input logic [NUM_SRC-1:0] en);
        return |(st & en);
    endfunction

    function automatic logic q_tok_set(input q_state_e s);
        return (s == Q_HEAD) || (s == Q_FULL);
    endfunction

endpackage

// File: rtl/usb_irq_err_edge.sv
module usb_irq_err_edge
    import usb_irq_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ERR_W-1:0] err_i,
    output logic             rise_o
);
    logic [ERR_W-1:0] prev_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= err_i;
            seen_q <= 1'b1;
        end
    end

    assign rise_o = |(err_i & ~prev_q);

    AST_ERR_STEADY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $stable(err_i)) |-> !rise_o); // R7

endmodule

// File: rtl/usb_irq_tok_queue.sv
module usb_irq_tok_queue
    import usb_irq_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              clr_i,
    output logic              tok_o,
    output logic [WORD_W-1:0] word_o,
    output logic              ovf_o
);
    q_state_e          st_q,   st_d;
    logic [WORD_W-1:0] head_q, head_d;
    logic [WORD_W-1:0] hold_q, hold_d;
    logic              ovf_q,  ovf_d;

    always_comb begin
        st_d   = st_q;
        head_d = head_q;
        hold_d = hold_q;
        ovf_d  = ovf_q;
        unique case (st_q)
            Q_EMPTY: begin
                if (done_i) begin
                    st_d   = Q_HEAD;
                    head_d = word_i;
                end
            end
            Q_HEAD: begin
                if (clr_i && done_i) begin
                    head_d = word_i;
                end else if (clr_i) begin
                    st_d   = Q_EMPTY;
                    head_d = '0;
                    ovf_d  = 1'b0;
                end else if (done_i) begin
                    st_d   = Q_FULL;
                    hold_d = word_i;
                end
            end
            Q_FULL: begin
                if (clr_i) begin
                    st_d   = Q_REFILL;
                    head_d = '0;
                end
                if (done_i) begin
                    ovf_d = 1'b1;
                end
            end
            Q_REFILL: begin
                head_d = hold_q;
                if (done_i) begin
                    st_d   = Q_FULL;
                    hold_d = word_i;
                end else begin
                    st_d   = Q_HEAD;
                end
            end
            default: st_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= Q_EMPTY;
            head_q <= '0;
            hold_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            head_q <= head_d;
            hold_q <= hold_d;
            ovf_q  <= ovf_d;
        end
    end

    assign tok_o  = q_tok_set(st_q);
    assign word_o = head_q;
    assign ovf_o  = ovf_q;

    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (rst)
        (st_q == Q_EMPTY && done_i) |=> (tok_o && word_o == $past(word_i))); // R9
    AST_REFILL_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (st_q == Q_REFILL) |=> tok_o); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (st_q == Q_HEAD && clr_i && !done_i) |=> (!tok_o && word_o == '0)); // R11
    AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (rst)
        (st_q == Q_FULL && done_i && !clr_i) |=> ovf_o); // R12
    AST_SAME_CYCLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (st_q == Q_HEAD && clr_i && done_i) |=> (tok_o && word_o == $past(word_i))); // R13

endmodule

// File: rtl/usb_irq_bits.sv
module usb_irq_bits
    import usb_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               tok_i,
    output logic [NUM_SRC-1:0] stat_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (i == B_TOKDN) begin : g_tok
            logic unused_tok;
            assign unused_tok = set_i[i] ^ clr_i[i];
            assign stat_o[i]  = tok_i;
        end else begin : g_flop
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (set_i[i]) begin
                    bit_q <= 1'b1;
                end else if (clr_i[i]) begin
                    bit_q <= 1'b0;
                end
            end
            assign stat_o[i] = bit_q;

            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                set_i[i] |=> stat_o[i]); // R4
            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (clr_i[i] && !set_i[i]) |=> !stat_o[i]); // R3
            AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
                (stat_o[i] && !clr_i[i]) |=> stat_o[i]); // R3
        end
    end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode_i,
    input  logic              stall_i,
    input  logic              attach_i,
    input  logic              resume_i,
    input  logic              sleep_i,
    input  logic              sof_i,
    input  logic              bus_rst_i,
    input  logic [ERR_W-1:0]  err_flags_i,
    input  logic              tok_done_i,
    input  logic [WORD_W-1:0] tok_word_i,
    input  logic              otg_irq_i,
    input  logic [7:0]        irq_en_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_data_o,
    output logic [WORD_W-1:0] xfer_stat_o,
    output logic              xfer_ovf_o,
    output logic              irq_o
);
    irq_vec_t           set_v;
    logic [NUM_SRC-1:0] clr_v;
    logic [NUM_SRC-1:0] stat_v;
    logic               err_rise;
    logic               tok_bit;

    usb_irq_err_edge #(.ERR_W(ERR_W)) i_err_edge (
        .clk    (clk),
        .rst    (rst),
        .err_i  (err_flags_i),
        .rise_o (err_rise)
    );

    usb_irq_tok_queue #(.WORD_W(WORD_W)) i_tok_queue (
        .clk    (clk),
        .rst    (rst),
        .done_i (tok_done_i),
        .word_i (tok_word_i),
        .clr_i  (wr_en_i && wr_data_i[B_TOKDN]),
        .tok_o  (tok_bit),
        .word_o (xfer_stat_o),
        .ovf_o  (xfer_ovf_o)
    );

    always_comb begin
        set_v        = '0;
        set_v.stall  = stall_i;
        set_v.attach = attach_i && host_mode_i;
        set_v.resume = resume_i;
        set_v.sleep  = sleep_i;
        set_v.tok    = 1'b0;
        set_v.sof    = sof_i;
        set_v.err    = err_rise;
        set_v.busrst = bus_rst_i;
        clr_v        = wr_en_i ? wr_data_i : '0;
    end

    usb_irq_bits i_bits (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .tok_i  (tok_bit),
        .stat_o (stat_v)
    );

    assign rd_data_o = stat_v;
    assign irq_o     = irq_any(stat_v, irq_en_i) || otg_irq_i;

    AST_OTG_PASSES: assert property (@(posedge clk) disable iff (rst)
        otg_irq_i |-> irq_o); // R5
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!otg_irq_i && ((rd_data_o & irq_en_i) == 8'h00)) |-> !irq_o); // R5
    AST_ATTACH_HOST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!host_mode_i && !rd_data_o[B_ATTACH]) |=> !rd_data_o[B_ATTACH]); // R8
    AST_ERR_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        err_rise |=> rd_data_o[B_ERR]); // R7

endmodule

// File: tb/test_usb_irq_status.sv
module test_usb_irq_status;
    localparam int WORD_W = 8;
    localparam int ERR_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_mode = 1'b0;
    logic stall = 0, attach = 0, resume = 0, sleep = 0, sof = 0, busrst = 0;
    logic [ERR_W-1:0]  errf = '0;
    logic              tdone = 0;
    logic [WORD_W-1:0] tword = '0;
    logic              otg = 0;
    logic [7:0]        en = '0;
    logic              wr_en = 0;
    logic [7:0]        wr_data = '0;
    logic [7:0]        rd_data;
    logic [WORD_W-1:0] xfer;
    logic              ovf, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    logic [7:0]        m_bits;
    int                m_q;       // 0 empty, 1 head, 2 full, 3 refill
    logic [WORD_W-1:0] m_head, m_hold;
    logic              m_ovf;
    logic [ERR_W-1:0]  m_prev;

    always #5 clk = ~clk;

    usb_irq_status #(.WORD_W(WORD_W), .ERR_W(ERR_W)) i_usb_irq_status (
        .clk(clk), .rst(rst), .host_mode_i(host_mode),
        .stall_i(stall), .attach_i(attach), .resume_i(resume), .sleep_i(sleep),
        .sof_i(sof), .bus_rst_i(busrst), .err_flags_i(errf),
        .tok_done_i(tdone), .tok_word_i(tword), .otg_irq_i(otg),
        .irq_en_i(en), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .xfer_stat_o(xfer), .xfer_ovf_o(ovf), .irq_o(irq)
    );

    function automatic logic [7:0] exp_rd();
        logic [7:0] r = m_bits;
        r[3] = (m_q == 1) || (m_q == 2);
        return r;
    endfunction

    function automatic logic exp_irq();
        return (|(exp_rd() & en)) || otg;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [7:0] setv;
        logic [7:0] clrv;
        logic       clr_t;
        if (rst) begin
            m_bits = '0; m_q = 0; m_head = '0; m_hold = '0; m_ovf = 0; m_prev = '0;
            return;
        end
        setv = {stall, attach && host_mode, resume, sleep, 1'b0, sof,
                |(errf & ~m_prev), busrst};
        clrv = wr_en ? wr_data : 8'h00;
        m_prev = errf;
        m_bits = ((m_bits & ~clrv) | setv) & 8'hF7;
        clr_t = clrv[3];
        case (m_q)
            0: if (tdone) begin m_q = 1; m_head = tword; end
            1: if (clr_t && tdone) m_head = tword;
               else if (clr_t) begin m_q = 0; m_head = '0; m_ovf = 0; end
               else if (tdone) begin m_q = 2; m_hold = tword; end
            2: begin
                if (clr_t) begin m_q = 3; m_head = '0; end
                if (tdone) m_ovf = 1;
            end
            default: begin
                m_head = m_hold;
                if (tdone) begin m_q = 2; m_hold = tword; end
                else m_q = 1;
            end
        endcase
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R3 status read", rd_data, exp_rd());
        chk("R10 xfer word", xfer, m_head);
        chk("R12 overflow", ovf, m_ovf);
        chk("R5 irq line", irq, exp_irq());
    endtask

    task automatic quiet();
        stall = 0; attach = 0; resume = 0; sleep = 0; sof = 0; busrst = 0;
        tdone = 0; wr_en = 0; wr_data = '0;
    endtask

    task automatic wclr(input logic [7:0] d);
        wr_en = 1; wr_data = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        tick(); tick();
        rst = 0;
        // R1: reset values
        chk("R1 reset read", rd_data, 8'h00);
        chk("R1 reset word", xfer, '0);
        chk("R1 reset ovf", ovf, 1'b0);
        chk("R1 reset irq", irq, 1'b0);

        // R2: each source at its position
        host_mode = 1;
        stall = 1; tick(); quiet(); chk("R2 stall bit7", rd_data, 8'h80); wclr(8'hFF); tick(); quiet();
        attach = 1; tick(); quiet(); chk("R2 attach bit6", rd_data, 8'h40); wclr(8'hFF); tick(); quiet();
        resume = 1; tick(); quiet(); chk("R2 resume bit5", rd_data, 8'h20); wclr(8'hFF); tick(); quiet();
        sleep = 1; tick(); quiet(); chk("R2 sleep bit4", rd_data, 8'h10); wclr(8'hFF); tick(); quiet();
        sof = 1; tick(); quiet(); chk("R2 sof bit2", rd_data, 8'h04); wclr(8'hFF); tick(); quiet();
        busrst = 1; tick(); quiet(); chk("R2 busrst bit0", rd_data, 8'h01); wclr(8'hFF); tick(); quiet();
        tdone = 1; tword = 8'h5A; tick(); quiet();
        chk("R2 tok bit3", rd_data, 8'h08);
        chk("R9 first word", xfer, 8'h5A);
        wclr(8'h08); tick(); quiet();
        chk("R11 cleared word", xfer, 8'h00);
        chk("R11 tok low", rd_data[3], 1'b0);

        // R3: ones clear, zeros keep
        stall = 1; sof = 1; tick(); quiet();
        wclr(8'h04); tick(); quiet();
        chk("R3 zero keeps stall", rd_data, 8'h80);
        wclr(8'h00); tick(); quiet();
        chk("R3 write zero no effect", rd_data, 8'h80);

        // R4: set wins over clear
        stall = 1; wclr(8'h80); tick(); quiet();
        chk("R4 set wins", rd_data[7], 1'b1);
        wclr(8'hFF); tick(); quiet();

        // R5, R6: mask and raw read
        resume = 1; en = 8'h00; tick(); quiet();
        chk("R6 raw read masked", rd_data, 8'h20);
        chk("R5 masked irq low", irq, 1'b0);
        en = 8'h20; tick();
        chk("R5 enabled irq high", irq, 1'b1);
        en = 8'h00; otg = 1; tick();
        chk("R5 otg irq", irq, 1'b1);
        otg = 0; wclr(8'hFF); tick(); quiet();

        // R7: error on rising flag only
        errf = 8'h04; tick();
        chk("R7 error set", rd_data[1], 1'b1);
        wclr(8'h02); tick(); quiet(); tick();
        chk("R7 steady flag no reset", rd_data[1], 1'b0);
        errf = 8'h84; tick();
        chk("R7 new flag sets", rd_data[1], 1'b1);
        errf = 8'h00; wclr(8'hFF); tick(); quiet();

        // R8: attach needs host mode
        host_mode = 0; attach = 1; tick(); quiet();
        chk("R8 attach ignored", rd_data[6], 1'b0);

        // R10, R12, R13: queue
        tdone = 1; tword = 8'hA1; tick();
        tword = 8'hB2; tick();
        tword = 8'hC3; tick(); quiet();
        chk("R12 drop sets ovf", ovf, 1'b1);
        chk("R12 head kept", xfer, 8'hA1);
        wclr(8'h08); tick(); quiet();
        chk("R10 gap tok low", rd_data[3], 1'b0);
        chk("R10 gap word zero", xfer, 8'h00);
        tick();
        chk("R10 refill tok", rd_data[3], 1'b1);
        chk("R10 refill word", xfer, 8'hB2);
        wclr(8'h08); tdone = 1; tword = 8'hD4; tick(); quiet();
        chk("R13 tok kept", rd_data[3], 1'b1);
        chk("R13 new word", xfer, 8'hD4);
        wclr(8'h08); tick(); quiet();
        chk("R12 ovf drained", ovf, 1'b0);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            stall  = ($urandom % 8) == 0;
            attach = ($urandom % 8) == 0;
            resume = ($urandom % 8) == 0;
            sleep  = ($urandom % 8) == 0;
            sof    = ($urandom % 8) == 0;
            busrst = ($urandom % 8) == 0;
            tdone  = ($urandom % 4) == 0;
            tword  = WORD_W'($urandom);
            wr_en  = ($urandom % 3) == 0;
            wr_data = 8'($urandom);
            otg    = ($urandom % 16) == 0;
            if (($urandom % 64) == 0) en = 8'($urandom);
            if (($urandom % 100) == 0) host_mode = ~host_mode;
            if (($urandom % 16) == 0) errf = ERR_W'($urandom) & ERR_W'($urandom);
            tick();
        end
        quiet();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule